// File: doc/BRIEF.md
# Dual-Cluster Micro-op Queue Merger

The merger sits between two independent decode clusters and a six-wide rename stage. Fetch blocks are handed to the clusters in strict alternation. The first block after reset or flush goes to cluster 0, the next to cluster 1, and so on. Each cluster appends its decoded micro-ops, one per cycle, to its own 16-entry queue. Every micro-op carries a payload, a 256-bit flag, a block sequence tag and an end-of-block flag. The end-of-block flag is set on the last micro-op of each fetch block.

Every cycle the merger looks at the heads of both queues together. It assembles one group of up to six output slots in program order. It drains the current cluster until it consumes a micro-op marked end-of-block, then continues from the other cluster's queue within the same cycle. A micro-op flagged 256-bit is emitted as two 128-bit halves, and each half takes its own slot. If only the low half fits in the current group, the high half opens the next group.

A stall input holds the group and blocks all dequeues. A flush input empties both queues and clears any half-emitted micro-op. It also makes cluster 0 the expected cluster again.

Top module: `uopq_merge`

## Requirements
- R1: Output slots, read slot 0 upward and cycle after cycle, reproduce the program order of micro-ops. Each slot carries the payload and sequence tag of its source micro-op. The first block after reset or flush is taken from cluster 0.
- R2: One group holds up to six slots and may take micro-ops from both queues in the same cycle, crossing a cluster boundary more than once.
- R3: The merger moves to the other queue only after consuming a micro-op whose end-of-block flag is set. While the current block is incomplete, nothing is taken from the other queue, even if that queue has entries.
- R4: `out_half_o` encodes 2'b00 for an unsplit micro-op, 2'b01 for the low half and 2'b10 for the high half of a 256-bit micro-op. A low half in slot s<5 is followed by the high half of the same payload in slot s+1.
- R5: A low half in slot 5 of a consumed group is followed by its high half in slot 0 of the next group.
- R6: Valid slots are contiguous from slot 0. The group ends at the first micro-op that is not yet in its queue.
- R7: While `stall_i` is high, nothing is dequeued, and slots valid at the start of the stall keep their contents.
- R8: Each queue holds 16 entries. Its `wr_ready_o` bit is low when it is full, and a write presented while full is dropped.
- R9: `flush_i` empties both queues and clears a pending high half. After the flush, no slot is valid, both ready bits are high, and the next block comes from cluster 0.
- R10: After reset, no slot is valid and both ready bits are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty both queues, restart at cluster 0 |
| stall_i | input | 1 | Hold the group, no dequeue |
| wr_valid_i | input | 2 | Per-cluster write strobe |
| wr_uop_i | input | 2x16 | Per-cluster micro-op payload |
| wr_wide_i | input | 2 | Per-cluster 256-bit flag |
| wr_eob_i | input | 2 | Per-cluster end-of-block flag |
| wr_seq_i | input | 2x8 | Per-cluster block sequence tag |
| wr_ready_o | output | 2 | Per-cluster queue not full |
| out_valid_o | output | 6 | Slot valid, contiguous from slot 0 |
| out_uop_o | output | 6x16 | Slot payload |
| out_half_o | output | 6x2 | Slot half code (00 whole, 01 low, 10 high) |
| out_seq_o | output | 6x8 | Slot sequence tag |

## Verification
The assertions check the following on every cycle: the slot-valid pattern stays contiguous, every low half is paired with its high half inside a group, a half spilled from slot 5 reappears in slot 0, stalled slots are held, the queue occupancy stays in range, full writes are dropped, and flush clears both queues. Other behaviour can only be shown by the bench's scenarios, because it depends on what was written and in which order. This includes that the merged stream matches program order, that groups are as large as the available micro-ops allow, that the other cluster is not entered before end-of-block, and that a flush discards a pending high half.

// File: rtl/uopq_pkg.sv
package uopq_pkg;
  typedef enum logic [1:0] {
    HALF_FULL = 2'b00,
    HALF_LO   = 2'b01,
    HALF_HI   = 2'b10
  } half_e;
endpackage

// File: rtl/uopq_fifo.sv
module uopq_fifo #(
  parameter int DEPTH = 16,
  parameter int UOP_W = 16,
  parameter int SEQ_W = 8,
  parameter int WIN   = 6,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int DQ_W  = $clog2(WIN + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      wr_valid_i,
  input  logic [UOP_W-1:0]          wr_uop_i,
  input  logic                      wr_wide_i,
  input  logic                      wr_eob_i,
  input  logic [SEQ_W-1:0]          wr_seq_i,
  output logic                      wr_ready_o,
  input  logic [DQ_W-1:0]           deq_i,
  output logic [CNT_W-1:0]          cnt_o,
  output logic [WIN-1:0][UOP_W-1:0] win_uop_o,
  output logic [WIN-1:0]            win_wide_o,
  output logic [WIN-1:0]            win_eob_o,
  output logic [WIN-1:0][SEQ_W-1:0] win_seq_o
);
  logic [UOP_W-1:0] mem_uop [DEPTH];
  logic             mem_wide[DEPTH];
  logic             mem_eob [DEPTH];
  logic [SEQ_W-1:0] mem_seq [DEPTH];

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push;

  assign wr_ready_o = (cnt_q != CNT_W'(DEPTH));
  assign push       = wr_valid_i && wr_ready_o && !flush_i;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      rd_ptr_q <= rd_ptr_q + PTR_W'(deq_i);
      cnt_q    <= cnt_q + CNT_W'(push) - CNT_W'(deq_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) begin
      mem_uop[wr_ptr_q]  <= wr_uop_i;
      mem_wide[wr_ptr_q] <= wr_wide_i;
      mem_eob[wr_ptr_q]  <= wr_eob_i;
      mem_seq[wr_ptr_q]  <= wr_seq_i;
    end
  end

  // head window: entry k of the queue, valid when k < cnt_o
  for (genvar k = 0; k < WIN; k++) begin : g_win
    logic [PTR_W-1:0] idx;
    assign idx           = rd_ptr_q + PTR_W'(k);
    assign win_uop_o[k]  = mem_uop[idx];
    assign win_wide_o[k] = mem_wide[idx];
    assign win_eob_o[k]  = mem_eob[idx];
    assign win_seq_o[k]  = mem_seq[idx];
  end

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  a_r8_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_ready_o && !flush_i && deq_i == '0) |=> (cnt_q == CNT_W'(DEPTH)));

  a_r9_flush_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0 && wr_ready_o));

  a_r7_deq_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(deq_i) <= cnt_q);
endmodule

// File: rtl/uopq_pick.sv
module uopq_pick import uopq_pkg::*; #(
  parameter int UOP_W = 16,
  parameter int SEQ_W = 8,
  parameter int WIN   = 6,
  parameter int CNT_W = 5,
  localparam int DQ_W = $clog2(WIN + 1),
  localparam int IX_W = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic                            cur_i,
  input  logic                            pend_i,
  input  logic [1:0][CNT_W-1:0]           cnt_i,
  input  logic [1:0][WIN-1:0][UOP_W-1:0]  win_uop_i,
  input  logic [1:0][WIN-1:0]             win_wide_i,
  input  logic [1:0][WIN-1:0]             win_eob_i,
  input  logic [1:0][WIN-1:0][SEQ_W-1:0]  win_seq_i,
  output logic [WIN-1:0]                  valid_o,
  output logic [WIN-1:0][UOP_W-1:0]       uop_o,
  output logic [WIN-1:0][1:0]             half_o,
  output logic [WIN-1:0][SEQ_W-1:0]       seq_o,
  output logic [1:0][DQ_W-1:0]            deq_o,
  output logic                            cur_o,
  output logic                            pend_o
);
  always_comb begin
    logic            c;
    logic            pend;
    logic            stop;
    logic            adv;
    logic [DQ_W-1:0] k [2];
    logic [IX_W-1:0] ix;
    c       = cur_i;
    pend    = pend_i;
    stop    = 1'b0;
    adv     = 1'b0;
    k[0]    = '0;
    k[1]    = '0;
    ix      = '0;
    valid_o = '0;
    uop_o   = '0;
    half_o  = '0;
    seq_o   = '0;
    for (int s = 0; s < WIN; s++) begin
      if (!stop) begin
        if (CNT_W'(k[c]) >= cnt_i[c]) begin
          stop = 1'b1;  // keep order: never skip a missing micro-op
        end else begin
          ix         = IX_W'(k[c]);
          valid_o[s] = 1'b1;
          uop_o[s]   = win_uop_i[c][ix];
          seq_o[s]   = win_seq_i[c][ix];
          if (pend) begin
            half_o[s] = HALF_HI;
            pend      = 1'b0;
            adv       = 1'b1;
          end else if (win_wide_i[c][ix]) begin
            half_o[s] = HALF_LO;
            pend      = 1'b1;
            adv       = 1'b0;
          end else begin
            half_o[s] = HALF_FULL;
            adv       = 1'b1;
          end
          if (adv) begin
            k[c] = k[c] + DQ_W'(1);
            if (win_eob_i[c][ix]) c = ~c;
          end
        end
      end
    end
    deq_o[0] = k[0];
    deq_o[1] = k[1];
    cur_o    = c;
    pend_o   = pend;
  end
endmodule

// File: rtl/uopq_merge.sv
module uopq_merge import uopq_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int OUT_W = 6,
  parameter int UOP_W = 16,
  parameter int SEQ_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic                        stall_i,
  input  logic [1:0]                  wr_valid_i,
  input  logic [1:0][UOP_W-1:0]       wr_uop_i,
  input  logic [1:0]                  wr_wide_i,
  input  logic [1:0]                  wr_eob_i,
  input  logic [1:0][SEQ_W-1:0]       wr_seq_i,
  output logic [1:0]                  wr_ready_o,
  output logic [OUT_W-1:0]            out_valid_o,
  output logic [OUT_W-1:0][UOP_W-1:0] out_uop_o,
  output logic [OUT_W-1:0][1:0]       out_half_o,
  output logic [OUT_W-1:0][SEQ_W-1:0] out_seq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int DQ_W  = $clog2(OUT_W + 1);

  logic [1:0][CNT_W-1:0]            cnt;
  logic [1:0][OUT_W-1:0][UOP_W-1:0] win_uop;
  logic [1:0][OUT_W-1:0]            win_wide;
  logic [1:0][OUT_W-1:0]            win_eob;
  logic [1:0][OUT_W-1:0][SEQ_W-1:0] win_seq;
  logic [1:0][DQ_W-1:0]             pick_deq;
  logic [1:0][DQ_W-1:0]             deq_eff;
  logic                             cur_q, pend_q, cur_nxt, pend_nxt;

  for (genvar g = 0; g < 2; g++) begin : g_q
    assign deq_eff[g] = stall_i ? '0 : pick_deq[g];
    uopq_fifo #(
      .DEPTH(DEPTH), .UOP_W(UOP_W), .SEQ_W(SEQ_W), .WIN(OUT_W)
    ) u_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .wr_valid_i (wr_valid_i[g]),
      .wr_uop_i   (wr_uop_i[g]),
      .wr_wide_i  (wr_wide_i[g]),
      .wr_eob_i   (wr_eob_i[g]),
      .wr_seq_i   (wr_seq_i[g]),
      .wr_ready_o (wr_ready_o[g]),
      .deq_i      (deq_eff[g]),
      .cnt_o      (cnt[g]),
      .win_uop_o  (win_uop[g]),
      .win_wide_o (win_wide[g]),
      .win_eob_o  (win_eob[g]),
      .win_seq_o  (win_seq[g])
    );
  end

  uopq_pick #(
    .UOP_W(UOP_W), .SEQ_W(SEQ_W), .WIN(OUT_W), .CNT_W(CNT_W)
  ) u_pick (
    .cur_i      (cur_q),
    .pend_i     (pend_q),
    .cnt_i      (cnt),
    .win_uop_i  (win_uop),
    .win_wide_i (win_wide),
    .win_eob_i  (win_eob),
    .win_seq_i  (win_seq),
    .valid_o    (out_valid_o),
    .uop_o      (out_uop_o),
    .half_o     (out_half_o),
    .seq_o      (out_seq_o),
    .deq_o      (pick_deq),
    .cur_o      (cur_nxt),
    .pend_o     (pend_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (flush_i) begin
      cur_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (!stall_i) begin
      cur_q  <= cur_nxt;
      pend_q <= pend_nxt;
    end
  end

  a_r6_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o & (out_valid_o + OUT_W'(1))) == '0);

  for (genvar s = 0; s < OUT_W - 1; s++) begin : g_pair
    a_r4_lo_hi_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[s] && out_half_o[s] == HALF_LO) |->
        (out_valid_o[s+1] && out_half_o[s+1] == HALF_HI && out_uop_o[s+1] == out_uop_o[s]));
  end

  a_r5_spill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !flush_i && out_valid_o[OUT_W-1] && out_half_o[OUT_W-1] == HALF_LO) |=>
      (out_valid_o[0] && out_half_o[0] == HALF_HI && out_uop_o[0] == $past(out_uop_o[OUT_W-1])));

  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush_i && out_valid_o[0]) |=>
      (out_valid_o[0] && $stable(out_uop_o[0]) && $stable(out_half_o[0]) && $stable(out_seq_o[0])));

  a_r9_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (out_valid_o == '0));
endmodule

// File: tb/uopq_merge_tb.sv
module uopq_merge_tb;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 16;
  localparam int OUT_W  = 6;
  localparam int UOP_W  = 16;
  localparam int SEQ_W  = 8;
  localparam logic [1:0] H_FULL = 2'b00;
  localparam logic [1:0] H_LO   = 2'b01;
  localparam logic [1:0] H_HI   = 2'b10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0;
  logic stall_i = 1'b1;
  logic [1:0] wr_valid_i = '0;
  logic [1:0][UOP_W-1:0] wr_uop_i = '0;
  logic [1:0] wr_wide_i = '0;
  logic [1:0] wr_eob_i = '0;
  logic [1:0][SEQ_W-1:0] wr_seq_i = '0;
  logic [1:0] wr_ready_o;
  logic [OUT_W-1:0] out_valid_o;
  logic [OUT_W-1:0][UOP_W-1:0] out_uop_o;
  logic [OUT_W-1:0][1:0] out_half_o;
  logic [OUT_W-1:0][SEQ_W-1:0] out_seq_o;

  always #(CLK_NS/2) clk = ~clk;

  uopq_merge #(.DEPTH(DEPTH), .OUT_W(OUT_W), .UOP_W(UOP_W), .SEQ_W(SEQ_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i), .stall_i(stall_i),
    .wr_valid_i(wr_valid_i), .wr_uop_i(wr_uop_i), .wr_wide_i(wr_wide_i),
    .wr_eob_i(wr_eob_i), .wr_seq_i(wr_seq_i), .wr_ready_o(wr_ready_o),
    .out_valid_o(out_valid_o), .out_uop_o(out_uop_o),
    .out_half_o(out_half_o), .out_seq_o(out_seq_o)
  );

  // per-cluster write lists and expected output stream
  logic [UOP_W-1:0] wl_id  [2][512];
  logic             wl_wide[2][512];
  logic             wl_eob [2][512];
  logic [SEQ_W-1:0] wl_seq [2][512];
  int wl_n[2];
  int wptr[2];
  logic [UOP_W-1:0] exp_id  [4096];
  logic [1:0]       exp_half[4096];
  logic [SEQ_W-1:0] exp_seq [4096];
  int exp_n, ptr, blk_cnt, last_nv, uid;
  logic [1:0] rdy_q;
  int n_chk, n_fail;
  bit done;

  function automatic void wl_put(int c, logic [UOP_W-1:0] id, logic wide, logic eob, logic [SEQ_W-1:0] sq);
    wl_id[c][wl_n[c]] = id; wl_wide[c][wl_n[c]] = wide;
    wl_eob[c][wl_n[c]] = eob; wl_seq[c][wl_n[c]] = sq;
    wl_n[c]++;
  endfunction

  function automatic void exp_put(logic [UOP_W-1:0] id, logic wide, logic [SEQ_W-1:0] sq);
    if (wide) begin
      exp_id[exp_n] = id; exp_half[exp_n] = H_LO; exp_seq[exp_n] = sq; exp_n++;
      exp_id[exp_n] = id; exp_half[exp_n] = H_HI; exp_seq[exp_n] = sq; exp_n++;
    end else begin
      exp_id[exp_n] = id; exp_half[exp_n] = H_FULL; exp_seq[exp_n] = sq; exp_n++;
    end
  endfunction

  // blocks alternate clusters, starting at cluster 0 after reset or flush
  function automatic void add_block(int len, int wide_mask);
    int c = blk_cnt % 2;
    for (int i = 0; i < len; i++) begin
      wl_put(c, UOP_W'(uid), wide_mask[i], (i == len - 1), SEQ_W'(blk_cnt));
      exp_put(UOP_W'(uid), wide_mask[i], SEQ_W'(blk_cnt));
      uid++;
    end
    blk_cnt++;
  endfunction

  function automatic void clear_model();
    for (int c = 0; c < 2; c++) begin wl_n[c] = 0; wptr[c] = 0; end
    exp_n = 0; ptr = 0; blk_cnt = 0;
  endfunction

  task automatic expect_int(string tag, int act, int exv);
    n_chk++;
    if (act != exv) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exv);
    end
  endtask

  task automatic check_group();
    int nv = 0;
    bit gap = 0;
    bit bad = 0;
    for (int s = 0; s < OUT_W; s++) begin
      if (!out_valid_o[s]) gap = 1;
      else if (gap) begin
        bad = 1;
        $display("FAIL R6 slot %0d valid after an empty slot: actual 1 expected 0", s);
      end else if (ptr + s >= exp_n) begin
        bad = 1; nv++;
        $display("FAIL R1/R8 slot %0d: actual id %0h expected no micro-op", s, out_uop_o[s]);
      end else begin
        if (out_uop_o[s] !== exp_id[ptr+s] || out_seq_o[s] !== exp_seq[ptr+s] ||
            out_half_o[s] !== exp_half[ptr+s]) begin
          bad = 1;
          $display("FAIL R1/R4/R7 slot %0d: actual id %0h seq %0h half %0d expected id %0h seq %0h half %0d",
                   s, out_uop_o[s], out_seq_o[s], out_half_o[s],
                   exp_id[ptr+s], exp_seq[ptr+s], exp_half[ptr+s]);
        end
        nv++;
      end
    end
    last_nv = nv;
    n_chk++;
    if (bad) n_fail++;
  endtask

  // one cycle: account writes taken at the last edge, check the group, drive the next edge
  task automatic tick(input bit st, input int wr_pct);
    @(negedge clk);
    for (int c = 0; c < 2; c++) if (wr_valid_i[c] && rdy_q[c]) wptr[c]++;
    check_group();
    stall_i = st;
    if (!st) ptr += last_nv;
    for (int c = 0; c < 2; c++) begin
      if (wptr[c] < wl_n[c] && int'($urandom % 100) < wr_pct) begin
        wr_valid_i[c] = 1'b1;
        wr_uop_i[c]   = wl_id[c][wptr[c]];
        wr_wide_i[c]  = wl_wide[c][wptr[c]];
        wr_eob_i[c]   = wl_eob[c][wptr[c]];
        wr_seq_i[c]   = wl_seq[c][wptr[c]];
      end else begin
        wr_valid_i[c] = 1'b0;
      end
    end
    rdy_q = wr_ready_o;
  endtask

  task automatic preload();
    while (wptr[0] < wl_n[0] || wptr[1] < wl_n[1]) tick(1'b1, 100);
  endtask

  task automatic drain(input int st_pct, input int wr_pct);
    int n = 0;
    while ((ptr < exp_n || wptr[0] < wl_n[0] || wptr[1] < wl_n[1]) && n < 20000) begin
      tick(int'($urandom % 100) < st_pct, wr_pct);
      n++;
    end
    expect_int("R1 stream fully delivered", ptr, exp_n);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1'b1; stall_i = 1'b1; wr_valid_i = '0;
    @(negedge clk);
    flush_i = 1'b0;
    rdy_q = wr_ready_o;
    clear_model();
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired: actual progress %0d expected %0d", ptr, exp_n);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    n_chk = 0; n_fail = 0; uid = 1; done = 0; last_nv = 0;
    clear_model();
    rdy_q = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    expect_int("R10 no valid slot after reset", int'(out_valid_o), 0);
    expect_int("R10 both ready after reset", int'(wr_ready_o), 3);
    rdy_q = wr_ready_o;

    // R2 splice across both clusters in one group
    add_block(2, 'b00);
    add_block(2, 'b01);
    add_block(2, 'b10);
    preload();
    tick(1'b0, 0);
    expect_int("R2 six-slot group spliced across clusters", last_nv, 6);
    tick(1'b0, 0);
    expect_int("R4 wide micro-op occupies two slots", last_nv, 2);

    // R5 high half spills to slot 0 of next group
    add_block(6, 'b100000);
    preload();
    tick(1'b0, 0);
    expect_int("R5 group ends on low half", int'(out_half_o[OUT_W-1]), int'(H_LO));
    tick(1'b0, 0);
    expect_int("R5 spilled high half alone", last_nv, 1);
    expect_int("R5 slot 0 is high half", int'(out_half_o[0]), int'(H_HI));

    // R3 no switch before end-of-block
    wl_put(0, UOP_W'(uid), 1'b0, 1'b0, SEQ_W'(blk_cnt)); exp_put(UOP_W'(uid), 1'b0, SEQ_W'(blk_cnt));
    uid++;
    wl_put(1, UOP_W'(uid + 1), 1'b0, 1'b1, SEQ_W'(blk_cnt + 1));
    preload();
    tick(1'b0, 0);
    expect_int("R3 only open block's micro-op emitted", last_nv, 1);
    tick(1'b0, 0);
    expect_int("R3 other queue untouched before end-of-block", last_nv, 0);
    wl_put(0, UOP_W'(uid), 1'b0, 1'b1, SEQ_W'(blk_cnt)); exp_put(UOP_W'(uid), 1'b0, SEQ_W'(blk_cnt));
    exp_put(UOP_W'(uid + 1), 1'b0, SEQ_W'(blk_cnt + 1));
    uid += 2; blk_cnt += 2;
    drain(0, 100);

    // R9 flush drops a pending high half and restarts at cluster 0
    add_block(6, 'b100000);
    preload();
    tick(1'b0, 0);
    do_flush();
    expect_int("R9 no valid slot after flush", int'(out_valid_o), 0);
    expect_int("R9 both ready after flush", int'(wr_ready_o), 3);
    add_block(1, 'b0);
    preload();
    tick(1'b0, 0);
    expect_int("R9 fresh micro-op is unsplit, no stale half", int'(out_half_o[0]), int'(H_FULL));
    drain(0, 100);
    do_flush();

    // R8 full queue: ready low, extra write dropped
    for (int i = 0; i < DEPTH; i++) begin
      wl_put(0, UOP_W'(uid), 1'b0, 1'b0, 8'h00); exp_put(UOP_W'(uid), 1'b0, 8'h00); uid++;
    end
    preload();
    expect_int("R8 ready low when full", int'(wr_ready_o[0]), 0);
    expect_int("R8 other queue still ready", int'(wr_ready_o[1]), 1);
    wl_put(0, 16'hdead, 1'b0, 1'b1, 8'h00);
    tick(1'b1, 100);
    tick(1'b1, 100);
    wl_n[0]--;
    tick(1'b1, 100);
    drain(0, 0);
    tick(1'b0, 0);
    expect_int("R8 write while full was dropped", last_nv, 0);
    do_flush();

    // random traffic with stalls (R1 R7)
    for (int b = 0; b < 120; b++) begin
      int len = 1 + int'($urandom % 5);
      int mask = 0;
      for (int i = 0; i < len; i++) if ($urandom % 4 == 0) mask |= (1 << i);
      add_block(len, mask);
    end
    drain(20, 75);
    do_flush();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule